// File: doc/BRIEF.md
# Outbound Address Translator with Viewport-Steered Register Window

This block translates outbound request addresses through a small set of programmable regions. Each region has a 64-bit base, an inclusive 32-bit lower limit that shares the upper base word, a 64-bit target, a transaction type code and an enable bit. The block compares each request with every enabled outbound region. A hit returns the target plus the offset of the address from the base, together with the region's type code and index. A miss returns the request address unchanged and raises a miss flag.

The regions are not separately addressed. Software first writes a viewport register to pick a direction (outbound or inbound) and a region index. It then reaches the chosen region's registers through one shared window of offsets. The block stores inbound banks and reads them back, but only the outbound bank takes part in translation. The type code tells memory (0), I/O (2), config type 0 (4) and config type 1 (5) apart. For config regions the lower target word carries bus, device and function numbers in its upper bits, and these pass into the translated address unchanged.

Top module: `ob_xlat_window`

## Requirements
- R1: After a synchronous reset every region is disabled, the viewport selects outbound region 0, all window registers read 0, and `out_valid` is 0.
- R2: The viewport register sits at offset 0x900. Bit 31 selects the direction (1 = inbound, 0 = outbound) and bit 0 selects the region index. A readback returns only those two bits, with all others 0.
- R3: Window writes go to the region chosen by the viewport: type control at 0x904 (type in bits 4:0), enable control at 0x908 (bit 31 enable, bit 30 BAR-match mode), lower base 0x90C, upper base 0x910, limit 0x914, lower target 0x918, upper target 0x91C. A read of the same offsets returns the selected region's register one cycle after `cfg_rd`.
- R4: A request hits an enabled region when base ≤ address ≤ {upper base, limit}, with both ends inclusive. The address one below the base misses, and so does the address one above the limit.
- R5: On a hit, `out_addr` = {upper target, lower target} + (address − base), computed over 64 bits, and `out_kind`/`out_region` give the region's type code and index.
- R6: When more than one region hits, the lowest-numbered region wins.
- R7: Window writes made while the viewport selects inbound leave outbound translation unchanged, and a read under the inbound viewport returns the inbound value.
- R8: When no enabled region hits, `out_miss` is 1 and `out_addr` equals the request address. A disabled region never hits.
- R9: Each request is answered exactly one cycle later: `out_valid` equals `req_valid` from the previous cycle.
- R10: A config-type region whose lower target holds bus (bits 31:24), device (bits 23:19) and function (bits 18:16) produces a translated address that keeps those fields, with the register offset in the low bits, and type code 4 or 5.
- R11: Writes to offsets outside 0x900–0x91C are ignored, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid one cycle after cfg_rd |
| req_valid | input | 1 | Outbound request valid |
| req_addr | input | 64 | Outbound request address |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 64 | Translated or pass-through address |
| out_miss | output | 1 | No region hit |
| out_region | output | 1 | Index of the winning region |
| out_kind | output | 5 | Type code of the winning region |

## Verification
A register write takes effect at the clock edge that samples it, so a request presented in the cycle after that edge already sees the new value. Read data and translation results are both registered and appear one edge after their strobe. The bench drives every strobe on a falling edge, holds it for one cycle, and samples the outputs at the next falling edge, so each result is read exactly one register stage after its stimulus. Once the strobe is released, the bench also checks that `out_valid` has dropped.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int DATA_W = 32;
  localparam int KIND_W = 5;

  localparam int OFS_VIEW   = 'h900;
  localparam int OFS_CTRL1  = 'h904;
  localparam int OFS_CTRL2  = 'h908;
  localparam int OFS_BASE_L = 'h90C;
  localparam int OFS_BASE_H = 'h910;
  localparam int OFS_LIMIT  = 'h914;
  localparam int OFS_TGT_L  = 'h918;
  localparam int OFS_TGT_H  = 'h91C;

  typedef struct packed {
    logic [DATA_W-1:0] base_lo;
    logic [DATA_W-1:0] base_hi;
    logic [DATA_W-1:0] limit;
    logic [DATA_W-1:0] tgt_lo;
    logic [DATA_W-1:0] tgt_hi;
    logic [KIND_W-1:0] kind;
    logic              en;
    logic              bar;
  } region_t;
endpackage

// File: rtl/obx_regbank.sv
module obx_regbank
  import obx_pkg::*;
#(
  parameter int REGIONS = 2,
  parameter int IDX_W   = 1,
  parameter int ADDR_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output region_t [REGIONS-1:0]     ob_regions,
  output logic                      vp_inbound
);
  logic             vp_dir;
  logic [IDX_W-1:0] vp_idx;
  logic             vp_ok;
  region_t          bank [2][REGIONS];
  region_t          sel;
  logic [DATA_W-1:0] rd_mux;

  assign vp_ok      = 32'(vp_idx) < 32'(REGIONS);
  assign vp_inbound = vp_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < REGIONS; r++)
          bank[d][r] <= '0;
    end else if (wr) begin
      if (addr == ADDR_W'(OFS_VIEW)) begin
        vp_dir <= wdata[DATA_W-1];
        vp_idx <= wdata[IDX_W-1:0];
      end else if (vp_ok) begin
        if (addr == ADDR_W'(OFS_CTRL1))  bank[vp_dir][vp_idx].kind    <= wdata[KIND_W-1:0];
        if (addr == ADDR_W'(OFS_CTRL2)) begin
          bank[vp_dir][vp_idx].en  <= wdata[31];
          bank[vp_dir][vp_idx].bar <= wdata[30];
        end
        if (addr == ADDR_W'(OFS_BASE_L)) bank[vp_dir][vp_idx].base_lo <= wdata;
        if (addr == ADDR_W'(OFS_BASE_H)) bank[vp_dir][vp_idx].base_hi <= wdata;
        if (addr == ADDR_W'(OFS_LIMIT))  bank[vp_dir][vp_idx].limit   <= wdata;
        if (addr == ADDR_W'(OFS_TGT_L))  bank[vp_dir][vp_idx].tgt_lo  <= wdata;
        if (addr == ADDR_W'(OFS_TGT_H))  bank[vp_dir][vp_idx].tgt_hi  <= wdata;
      end
    end
  end

  always_comb begin
    sel    = vp_ok ? bank[vp_dir][vp_idx] : '0;
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_VIEW)) begin
      rd_mux[DATA_W-1]  = vp_dir;
      rd_mux[IDX_W-1:0] = vp_idx;
    end
    else if (addr == ADDR_W'(OFS_CTRL1))  rd_mux[KIND_W-1:0] = sel.kind;
    else if (addr == ADDR_W'(OFS_CTRL2))  rd_mux[31:30] = {sel.en, sel.bar};
    else if (addr == ADDR_W'(OFS_BASE_L)) rd_mux = sel.base_lo;
    else if (addr == ADDR_W'(OFS_BASE_H)) rd_mux = sel.base_hi;
    else if (addr == ADDR_W'(OFS_LIMIT))  rd_mux = sel.limit;
    else if (addr == ADDR_W'(OFS_TGT_L))  rd_mux = sel.tgt_lo;
    else if (addr == ADDR_W'(OFS_TGT_H))  rd_mux = sel.tgt_hi;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  for (genvar r = 0; r < REGIONS; r++) begin : g_ob
    assign ob_regions[r] = bank[0][r];
  end
endmodule

// File: rtl/obx_region_match.sv
module obx_region_match
  import obx_pkg::*;
#(
  parameter int AW = 64
) (
  input  region_t       region,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] xaddr
);
  logic [AW-1:0] base, lim, tgt;

  assign base  = AW'({region.base_hi, region.base_lo});
  assign lim   = AW'({region.base_hi, region.limit});
  assign tgt   = AW'({region.tgt_hi, region.tgt_lo});
  assign hit   = region.en && (addr >= base) && (addr <= lim);
  assign xaddr = tgt + (addr - base);
endmodule

// File: rtl/obx_hit_pick.sv
module obx_hit_pick
  import obx_pkg::*;
#(
  parameter int REGIONS = 2,
  parameter int IDX_W   = 1,
  parameter int AW      = 64
) (
  input  logic [REGIONS-1:0]             hits,
  input  logic [REGIONS-1:0][AW-1:0]     xaddrs,
  input  logic [REGIONS-1:0][KIND_W-1:0] kinds,
  output logic                           any,
  output logic [IDX_W-1:0]               idx,
  output logic [AW-1:0]                  addr,
  output logic [KIND_W-1:0]              kind
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    addr = '0;
    kind = '0;
    for (int i = REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        addr = xaddrs[i];
        kind = kinds[i];
      end
    end
  end
endmodule

// File: rtl/ob_xlat_window.sv
module ob_xlat_window
  import obx_pkg::*;
#(
  parameter int REGIONS = 2,
  parameter int ADDR_W  = 12,
  parameter int AW      = 64,
  localparam int IDX_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  output logic              out_valid,
  output logic [AW-1:0]     out_addr,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_region,
  output logic [KIND_W-1:0] out_kind
);
  region_t [REGIONS-1:0]             ob_regions;
  logic                              vp_inbound;
  logic [REGIONS-1:0]                hits;
  logic [REGIONS-1:0][AW-1:0]        xaddrs;
  logic [REGIONS-1:0][KIND_W-1:0]    kinds;
  logic                              any_hit;
  logic [IDX_W-1:0]                  pick_idx;
  logic [AW-1:0]                     pick_addr;
  logic [KIND_W-1:0]                 pick_kind;

  obx_regbank #(.REGIONS(REGIONS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ob_regions(ob_regions),
    .vp_inbound(vp_inbound)
  );

  for (genvar r = 0; r < REGIONS; r++) begin : g_match
    obx_region_match #(.AW(AW)) i_match (
      .region(ob_regions[r]), .addr(req_addr),
      .hit(hits[r]), .xaddr(xaddrs[r])
    );
    assign kinds[r] = ob_regions[r].kind;
  end

  obx_hit_pick #(.REGIONS(REGIONS), .IDX_W(IDX_W), .AW(AW)) i_pick (
    .hits(hits), .xaddrs(xaddrs), .kinds(kinds),
    .any(any_hit), .idx(pick_idx), .addr(pick_addr), .kind(pick_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_miss   <= 1'b0;
      out_region <= '0;
      out_kind   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr   <= any_hit ? pick_addr : req_addr;
        out_miss   <= !any_hit;
        out_region <= pick_idx;
        out_kind   <= pick_kind;
      end
    end
  end
endmodule

// File: rtl/obx_checker.sv
module obx_checker
  import obx_pkg::*;
#(
  parameter int REGIONS = 2,
  parameter int AW      = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_wr,
  input logic [31:0]           cfg_rdata,
  input logic                  req_valid,
  input logic [AW-1:0]         req_addr,
  input logic                  out_valid,
  input logic [AW-1:0]         out_addr,
  input logic                  out_miss,
  input logic                  vp_inbound,
  input region_t [REGIONS-1:0] ob_regions
);
  logic [REGIONS-1:0] en_vec;
  always_comb
    for (int i = 0; i < REGIONS; i++) en_vec[i] = ob_regions[i].en;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid && cfg_rdata == 32'd0);

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R8
  passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_miss |-> out_addr == $past(req_addr));

  // R8
  all_disabled_miss_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && en_vec == '0 |=> out_miss);

  // R7
  inbound_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && vp_inbound |=> $stable(ob_regions));
endmodule

bind ob_xlat_window obx_checker #(.REGIONS(REGIONS), .AW(AW)) i_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
  .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
  .out_addr(out_addr), .out_miss(out_miss), .vp_inbound(vp_inbound),
  .ob_regions(ob_regions)
);

// File: tb/test_ob_xlat_window.sv
module test_ob_xlat_window;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        out_valid, out_miss;
  logic [63:0] out_addr;
  logic [0:0]  out_region;
  logic [4:0]  out_kind;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ob_xlat_window i_ob_xlat_window (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_miss(out_miss), .out_region(out_region),
    .out_kind(out_kind)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic req_chk(input string tag, input logic [63:0] a, input logic exp_miss,
                         input logic [63:0] exp_addr, input logic exp_reg, input logic [4:0] exp_kind);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(out_valid), 64'd1);
    chk({tag, " miss"}, 64'(out_miss), 64'(exp_miss));
    chk({tag, " addr"}, out_addr, exp_addr);
    if (!exp_miss) begin
      chk({tag, " region"}, 64'(out_region), 64'(exp_reg));
      chk({tag, " kind"}, 64'(out_kind), 64'(exp_kind));
    end
    @(negedge clk);
    chk({tag, " valid drop R9"}, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    rd_chk("R1 ctrl2", 12'h908, 32'h0);
    rd_chk("R1 viewport", 12'h900, 32'h0);
    req_chk("R1 passthrough", 64'h0000_0001_2000_0000, 1'b1, 64'h0000_0001_2000_0000, 1'b0, 5'd0);
  endtask

  task automatic t_viewport;
    wr(12'h900, 32'h8000_0001);
    rd_chk("R2 dir+idx", 12'h900, 32'h8000_0001);
    wr(12'h900, 32'hFFFF_FFFE);
    rd_chk("R2 masked", 12'h900, 32'h8000_0000);
    wr(12'h900, 32'h0);
  endtask

  task automatic t_program_r0;
    wr(12'h90C, 32'h2000_0000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h2000_FFFF);
    wr(12'h918, 32'h8000_0000);
    wr(12'h91C, 32'h0000_00AB);
    wr(12'h904, 32'h0000_0000);
    wr(12'h908, 32'h8000_0000);
    rd_chk("R3 limit", 12'h914, 32'h2000_FFFF);
    rd_chk("R3 tgt hi", 12'h91C, 32'h0000_00AB);
    rd_chk("R3 ctrl2", 12'h908, 32'h8000_0000);
  endtask

  task automatic t_bounds;
    req_chk("R4 at base", 64'h0000_0001_2000_0000, 1'b0, 64'h0000_00AB_8000_0000, 1'b0, 5'd0);
    req_chk("R4 at limit", 64'h0000_0001_2000_FFFF, 1'b0, 64'h0000_00AB_8000_FFFF, 1'b0, 5'd0);
    req_chk("R4 below base", 64'h0000_0001_1FFF_FFFF, 1'b1, 64'h0000_0001_1FFF_FFFF, 1'b0, 5'd0);
    req_chk("R4 above limit", 64'h0000_0001_2001_0000, 1'b1, 64'h0000_0001_2001_0000, 1'b0, 5'd0);
    req_chk("R5 offset", 64'h0000_0001_2000_1234, 1'b0, 64'h0000_00AB_8000_1234, 1'b0, 5'd0);
  endtask

  task automatic t_overlap;
    wr(12'h900, 32'h0000_0001);
    wr(12'h90C, 32'h2000_8000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h2001_0FFF);
    wr(12'h918, 32'h0000_0000);
    wr(12'h91C, 32'h4000_0000);
    wr(12'h904, 32'h0000_0002);
    wr(12'h908, 32'h8000_0000);
    req_chk("R6 both hit", 64'h0000_0001_2000_8000, 1'b0, 64'h0000_00AB_8000_8000, 1'b0, 5'd0);
    req_chk("R5 region1", 64'h0000_0001_2001_0000, 1'b0, 64'h4000_0000_0000_8000, 1'b1, 5'd2);
    req_chk("R4 r1 above", 64'h0000_0001_2001_1000, 1'b1, 64'h0000_0001_2001_1000, 1'b0, 5'd0);
  endtask

  task automatic t_inbound;
    wr(12'h900, 32'h8000_0000);
    wr(12'h90C, 32'hDEAD_0000);
    wr(12'h908, 32'h8000_0000);
    req_chk("R7 outbound kept", 64'h0000_0001_2000_0010, 1'b0, 64'h0000_00AB_8000_0010, 1'b0, 5'd0);
    rd_chk("R7 inbound read", 12'h90C, 32'hDEAD_0000);
    wr(12'h900, 32'h0000_0000);
    rd_chk("R7 outbound read", 12'h90C, 32'h2000_0000);
  endtask

  task automatic t_config;
    wr(12'h900, 32'h0000_0001);
    wr(12'h90C, 32'h1000_0000);
    wr(12'h910, 32'h0000_0000);
    wr(12'h914, 32'h1000_0FFF);
    wr(12'h918, 32'h032A_0000);
    wr(12'h91C, 32'h0000_0000);
    wr(12'h904, 32'hFFFF_FFE4);
    wr(12'h908, 32'hC000_0000);
    rd_chk("R3 type field", 12'h904, 32'h0000_0004);
    rd_chk("R3 bar bit", 12'h908, 32'hC000_0000);
    req_chk("R10 cfg bdf", 64'h0000_0000_1000_0104, 1'b0, 64'h0000_0000_032A_0104, 1'b1, 5'd4);
  endtask

  task automatic t_unmapped;
    wr(12'h920, 32'h1234_5678);
    rd_chk("R11 read zero", 12'h920, 32'h0);
    rd_chk("R11 limit intact", 12'h914, 32'h1000_0FFF);
    req_chk("R11 xlat intact", 64'h0000_0000_1000_0200, 1'b0, 64'h0000_0000_032A_0200, 1'b1, 5'd4);
  endtask

  task automatic t_disable;
    wr(12'h908, 32'h0000_0000);
    req_chk("R8 disabled", 64'h0000_0000_1000_0104, 1'b1, 64'h0000_0000_1000_0104, 1'b0, 5'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_viewport();
    t_program_r0();
    t_bounds();
    t_overlap();
    t_inbound();
    t_config();
    t_unmapped();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule